// File: doc/BRIEF.md
# Two-Port Synchronous Word Memory with Cross-Port Forwarding

This block is a synchronous memory with two independent ports, X and Y. Each port has its own address, write word, read word, write select, forwarding request, a pair of chip enables (one active low, one active high) and an asynchronous output enable. Both ports may read, write or forward in the same clock cycle. The array depth is set by a parameter and the word is 36 bits wide by default.

Forwarding copies the write word presented on one port into the other port's output register without using the array. When that other port also asks for a read, forwarding takes priority. When both ports use the same location in the same cycle, fixed rules apply. Two reads both return the stored word. A read against a write returns the contents held before the write. Two writes store the Y word.

All inputs except the output enables are registered on the rising clock edge. The registered request is acted on at the next edge, so read and forwarded words reach the output register one cycle after the edge that sampled them. Each port has its own valid flag. A tristate pad is modelled as a data bus plus a drive flag. The first cycle after reset is released is a settling cycle, and inputs presented during it are discarded.

Top module: `xy_sram`

## Requirements
- R1: A selected port with its write select low (read) and no forwarding from the peer loads the array word at its sampled address into its output register. The word appears with valid high one clock cycle after the edge that sampled the request. Valid is low after any edge that loads nothing.
- R2: A port is deselected when its active-low enable is sampled high or its active-high enable is sampled low. A deselected port stores nothing, leaves its output word unchanged with valid low, and cannot act as a forwarding source.
- R3: A selected port with its write select high (1 = write) stores its write word at its address. It does not load its own output register unless the peer forwards to it.
- R4: When port X is selected with its forwarding request high and port Y is selected, port Y's output loads port X's write word one cycle later, whatever Y's read or write select is.
- R5: When port Y is selected with its forwarding request high and port X is selected, port X's output loads port Y's write word one cycle later, taking priority over an X read.
- R6: When both ports read the same address in the same cycle, both return the stored word.
- R7: When one port writes an address and the other reads the same address in the same cycle, the reader gets the contents held before the write, and the new word is stored.
- R8: When both ports write the same address in the same cycle, the Y word is stored and the X word is discarded.
- R9: A port's drive flag equals valid AND NOT output-enable (output enable is active low). It follows the output enable without waiting for a clock edge.
- R10: During reset, valid, drive and the output words are 0. Requests sampled at the first rising edge after reset is released are discarded.
- R11: The output word holds its last loaded value through cycles in which nothing is loaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| x_addr | input | ADDR_W | Port X address |
| x_wdata | input | DATA_W | Port X write and forwarding word |
| x_wr | input | 1 | Port X write select (1 = write, 0 = read) |
| x_fwd | input | 1 | Forward the X write word to the Y output |
| x_en_n | input | 1 | Port X enable, active low |
| x_en | input | 1 | Port X enable, active high |
| x_oe_n | input | 1 | Port X output enable, active low, asynchronous |
| x_rdata | output | DATA_W | Port X output register |
| x_valid | output | 1 | Port X output loaded at the last edge |
| x_drive | output | 1 | Port X bus driven |
| y_addr | input | ADDR_W | Port Y address |
| y_wdata | input | DATA_W | Port Y write and forwarding word |
| y_wr | input | 1 | Port Y write select (1 = write, 0 = read) |
| y_fwd | input | 1 | Forward the Y write word to the X output |
| y_en_n | input | 1 | Port Y enable, active low |
| y_en | input | 1 | Port Y enable, active high |
| y_oe_n | input | 1 | Port Y output enable, active low, asynchronous |
| y_rdata | output | DATA_W | Port Y output register |
| y_valid | output | 1 | Port Y output loaded at the last edge |
| y_drive | output | 1 | Port Y bus driven |

## Verification
The bench builds the memory with ADDR_W = 6, giving 64 words of 36 bits. With so few words, random traffic from both ports lands on the same address often, so read-against-write and write-against-write collisions occur many times without being aimed at. The top word, address 63, is written and read directly, and the full 36-bit word carries patterns wider than 32 bits.

// File: rtl/xy_sram_pkg.sv
package xy_sram_pkg;

  typedef enum logic [1:0] {
    OUT_HOLD  = 2'd0,
    OUT_ARRAY = 2'd1,
    OUT_FWD   = 2'd2
  } out_src_e;

  // A port is live only when both of its enables agree.
  function automatic logic port_enabled(input logic en_n, input logic en);
    return !en_n && en;
  endfunction

  // Output register source for one port; peer forwarding beats a read.
  function automatic out_src_e out_source(input logic own_sel, input logic own_wr,
                                          input logic peer_sel, input logic peer_fwd);
    if (!own_sel)             return OUT_HOLD;
    if (peer_sel && peer_fwd) return OUT_FWD;
    if (!own_wr)              return OUT_ARRAY;
    return OUT_HOLD;
  endfunction

endpackage

// File: rtl/xy_sram_port_in.sv
module xy_sram_port_in
  import xy_sram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              en_n,
  input  logic              en,
  input  logic              wr,
  input  logic              fwd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              sel_q,
  output logic              wr_q,
  output logic              fwd_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q   <= 1'b0;
      wr_q    <= 1'b0;
      fwd_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      sel_q   <= accept && port_enabled(en_n, en);
      wr_q    <= wr;
      fwd_q   <= fwd;
      addr_q  <= addr;
      wdata_q <= wdata;
    end
  end

endmodule

// File: rtl/xy_sram_array.sv
module xy_sram_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              x_we,
  input  logic [ADDR_W-1:0] x_addr,
  input  logic [DATA_W-1:0] x_wdata,
  input  logic              y_we,
  input  logic [ADDR_W-1:0] y_addr,
  input  logic [DATA_W-1:0] y_wdata,
  output logic [DATA_W-1:0] x_rword,
  output logic [DATA_W-1:0] y_rword
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              x_shadowed;

  // Same-address double write: the Y word wins.
  assign x_shadowed = x_we && y_we && (x_addr == y_addr);

  always_ff @(posedge clk) begin
    if (x_we && !x_shadowed) mem[x_addr] <= x_wdata;
    if (y_we)                mem[y_addr] <= y_wdata;
  end

  // Reads see the contents before this edge's writes.
  assign x_rword = mem[x_addr];
  assign y_rword = mem[y_addr];

endmodule

// File: rtl/xy_sram_port_out.sv
module xy_sram_port_out
  import xy_sram_pkg::*;
#(
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  out_src_e          src,
  input  logic [DATA_W-1:0] array_word,
  input  logic [DATA_W-1:0] fwd_word,
  input  logic              oe_n,
  output logic [DATA_W-1:0] q,
  output logic              valid,
  output logic              drive
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q     <= '0;
      valid <= 1'b0;
    end else begin
      case (src)
        OUT_FWD: begin
          q     <= fwd_word;
          valid <= 1'b1;
        end
        OUT_ARRAY: begin
          q     <= array_word;
          valid <= 1'b1;
        end
        default: valid <= 1'b0;
      endcase
    end
  end

  assign drive = valid && !oe_n;

endmodule

// File: rtl/xy_sram.sv
module xy_sram
  import xy_sram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] x_addr,
  input  logic [DATA_W-1:0] x_wdata,
  input  logic              x_wr,
  input  logic              x_fwd,
  input  logic              x_en_n,
  input  logic              x_en,
  input  logic              x_oe_n,
  output logic [DATA_W-1:0] x_rdata,
  output logic              x_valid,
  output logic              x_drive,
  input  logic [ADDR_W-1:0] y_addr,
  input  logic [DATA_W-1:0] y_wdata,
  input  logic              y_wr,
  input  logic              y_fwd,
  input  logic              y_en_n,
  input  logic              y_en,
  input  logic              y_oe_n,
  output logic [DATA_W-1:0] y_rdata,
  output logic              y_valid,
  output logic              y_drive
);

  localparam int NPORT = 2;

  // Index 0 is port X, index 1 is port Y.
  logic [ADDR_W-1:0] in_addr  [NPORT];
  logic [DATA_W-1:0] in_wdata [NPORT];
  logic              in_wr    [NPORT];
  logic              in_fwd   [NPORT];
  logic              in_en_n  [NPORT];
  logic              in_en    [NPORT];
  logic              in_oe_n  [NPORT];

  logic              sel_q    [NPORT];
  logic              wr_q     [NPORT];
  logic              fwd_q    [NPORT];
  logic [ADDR_W-1:0] addr_q   [NPORT];
  logic [DATA_W-1:0] wdata_q  [NPORT];

  logic              wr_fire  [NPORT];
  logic              fwd_fire [NPORT];
  out_src_e          src      [NPORT];
  logic [DATA_W-1:0] rword    [NPORT];
  logic [DATA_W-1:0] out_q    [NPORT];
  logic              out_v    [NPORT];
  logic              out_drv  [NPORT];

  logic              ready_q;

  assign in_addr[0]  = x_addr;   assign in_addr[1]  = y_addr;
  assign in_wdata[0] = x_wdata;  assign in_wdata[1] = y_wdata;
  assign in_wr[0]    = x_wr;     assign in_wr[1]    = y_wr;
  assign in_fwd[0]   = x_fwd;    assign in_fwd[1]   = y_fwd;
  assign in_en_n[0]  = x_en_n;   assign in_en_n[1]  = y_en_n;
  assign in_en[0]    = x_en;     assign in_en[1]    = y_en;
  assign in_oe_n[0]  = x_oe_n;   assign in_oe_n[1]  = y_oe_n;

  // Settling cycle after reset: requests sampled while this is low are dropped.
  always_ff @(posedge clk) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    localparam int PEER = NPORT - 1 - p;

    xy_sram_port_in #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) in_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .accept  (ready_q),
      .en_n    (in_en_n[p]),
      .en      (in_en[p]),
      .wr      (in_wr[p]),
      .fwd     (in_fwd[p]),
      .addr    (in_addr[p]),
      .wdata   (in_wdata[p]),
      .sel_q   (sel_q[p]),
      .wr_q    (wr_q[p]),
      .fwd_q   (fwd_q[p]),
      .addr_q  (addr_q[p]),
      .wdata_q (wdata_q[p])
    );

    assign wr_fire[p]  = sel_q[p] && wr_q[p];
    assign fwd_fire[p] = sel_q[p] && fwd_q[p];
    assign src[p]      = out_source(sel_q[p], wr_q[p], sel_q[PEER], fwd_q[PEER]);

    xy_sram_port_out #(.DATA_W(DATA_W)) out_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .src        (src[p]),
      .array_word (rword[p]),
      .fwd_word   (wdata_q[PEER]),
      .oe_n       (in_oe_n[p]),
      .q          (out_q[p]),
      .valid      (out_v[p]),
      .drive      (out_drv[p])
    );
  end

  xy_sram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) array_i (
    .clk     (clk),
    .x_we    (wr_fire[0]),
    .x_addr  (addr_q[0]),
    .x_wdata (wdata_q[0]),
    .y_we    (wr_fire[1]),
    .y_addr  (addr_q[1]),
    .y_wdata (wdata_q[1]),
    .x_rword (rword[0]),
    .y_rword (rword[1])
  );

  assign x_rdata = out_q[0];
  assign x_valid = out_v[0];
  assign x_drive = out_drv[0];
  assign y_rdata = out_q[1];
  assign y_valid = out_v[1];
  assign y_drive = out_drv[1];

endmodule

// File: rtl/xy_sram_chk.sv
module xy_sram_chk #(
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ready,
  input logic              sel_x,
  input logic              sel_y,
  input logic              wr_x,
  input logic              wr_y,
  input logic              fwd_x,
  input logic              fwd_y,
  input logic [DATA_W-1:0] wd_x,
  input logic [DATA_W-1:0] wd_y,
  input logic              x_oe_n,
  input logic              y_oe_n,
  input logic              x_valid,
  input logic              y_valid,
  input logic              x_drive,
  input logic              y_drive,
  input logic [DATA_W-1:0] x_rdata,
  input logic [DATA_W-1:0] y_rdata
);

  // R9: the bus is never driven with the output enable inactive or with nothing loaded
  always_comb begin
    if (rst_n === 1'b1) begin
      assert_oe_gates_x_R9: assert (!(x_oe_n === 1'b1 && x_drive === 1'b1));
      assert_oe_gates_y_R9: assert (!(y_oe_n === 1'b1 && y_drive === 1'b1));
      assert_drive_needs_valid_R9: assert (!(x_drive === 1'b1 && x_valid !== 1'b1));
    end
  end

  assert_deselect_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_x |=> (!x_valid && $stable(x_rdata)));

  assert_read_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_x && !wr_x) |=> x_valid);

  assert_write_no_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_y && wr_y && !(sel_x && fwd_x)) |=> !y_valid);

  assert_fwd_x_to_y_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_x && fwd_x && sel_y) |=> (y_valid && y_rdata == $past(wd_x)));

  assert_fwd_y_to_x_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_y && fwd_y && sel_x) |=> (x_valid && x_rdata == $past(wd_y)));

  assert_settle_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (!sel_x && !sel_y));

endmodule

bind xy_sram xy_sram_chk #(.DATA_W(DATA_W)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .ready   (ready_q),
  .sel_x   (sel_q[0]),
  .sel_y   (sel_q[1]),
  .wr_x    (wr_q[0]),
  .wr_y    (wr_q[1]),
  .fwd_x   (fwd_q[0]),
  .fwd_y   (fwd_q[1]),
  .wd_x    (wdata_q[0]),
  .wd_y    (wdata_q[1]),
  .x_oe_n  (x_oe_n),
  .y_oe_n  (y_oe_n),
  .x_valid (x_valid),
  .y_valid (y_valid),
  .x_drive (x_drive),
  .y_drive (y_drive),
  .x_rdata (x_rdata),
  .y_rdata (y_rdata)
);

// File: tb/xy_sram_tb.sv
module xy_sram_tb_top;

  localparam int AW = 6;
  localparam int DW = 36;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [AW-1:0] xa = '0, ya = '0;
  logic [DW-1:0] xd = '0, yd = '0;
  logic xwr = 0, ywr = 0, xfw = 0, yfw = 0;
  logic xen_n = 1, xen = 0, yen_n = 1, yen = 0, xoe = 0, yoe = 0;
  logic [DW-1:0] x_rdata, y_rdata;
  logic x_valid, y_valid, x_drive, y_drive;

  xy_sram #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .x_addr(xa), .x_wdata(xd), .x_wr(xwr), .x_fwd(xfw), .x_en_n(xen_n), .x_en(xen),
    .x_oe_n(xoe), .x_rdata(x_rdata), .x_valid(x_valid), .x_drive(x_drive),
    .y_addr(ya), .y_wdata(yd), .y_wr(ywr), .y_fwd(yfw), .y_en_n(yen_n), .y_en(yen),
    .y_oe_n(yoe), .y_rdata(y_rdata), .y_valid(y_valid), .y_drive(y_drive)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // Reference model state
  bit [DW-1:0] mem_m [int];
  bit m_ready = 0;
  bit s_xsel = 0, s_xwr = 0, s_xfw = 0, s_ysel = 0, s_ywr = 0, s_yfw = 0;
  int s_xa = 0, s_ya = 0;
  bit [DW-1:0] s_xd = '0, s_yd = '0;
  bit [DW-1:0] mx_q = '0, my_q = '0;
  bit mx_v = 0, my_v = 0, mx_k = 1, my_k = 1;

  task automatic chk(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "x_valid", DW'(x_valid), DW'(mx_v));
    chk(tag, "y_valid", DW'(y_valid), DW'(my_v));
    chk(tag, "x_drive", DW'(x_drive), DW'(mx_v && !xoe));
    chk(tag, "y_drive", DW'(y_drive), DW'(my_v && !yoe));
    if (mx_k) chk(tag, "x_rdata", x_rdata, mx_q);
    if (my_k) chk(tag, "y_rdata", y_rdata, my_q);
  endtask

  // One clock: the model acts on what the design sampled one edge earlier.
  task automatic tick(string tag);
    bit nx, ny;
    bit [DW-1:0] rx, ry;
    bit kx, ky;
    @(posedge clk);
    @(negedge clk);
    if (!rst_n) begin
      m_ready = 0; s_xsel = 0; s_ysel = 0;
      mx_q = '0; my_q = '0; mx_v = 0; my_v = 0; mx_k = 1; my_k = 1;
    end else begin
      kx = mem_m.exists(s_xa); rx = kx ? mem_m[s_xa] : '0;
      ky = mem_m.exists(s_ya); ry = ky ? mem_m[s_ya] : '0;
      mx_v = 0; my_v = 0;
      if (s_xsel) begin
        if (s_ysel && s_yfw) begin mx_q = s_yd; mx_k = 1; mx_v = 1; end
        else if (!s_xwr)     begin mx_q = rx; mx_k = kx; mx_v = 1; end
      end
      if (s_ysel) begin
        if (s_xsel && s_xfw) begin my_q = s_xd; my_k = 1; my_v = 1; end
        else if (!s_ywr)     begin my_q = ry; my_k = ky; my_v = 1; end
      end
      if (s_xsel && s_xwr) mem_m[s_xa] = s_xd;
      if (s_ysel && s_ywr) mem_m[s_ya] = s_yd;
      nx = m_ready && !xen_n && xen;
      ny = m_ready && !yen_n && yen;
      s_xsel = nx; s_xwr = xwr; s_xfw = xfw; s_xa = int'(xa); s_xd = xd;
      s_ysel = ny; s_ywr = ywr; s_yfw = yfw; s_ya = int'(ya); s_yd = yd;
      m_ready = 1;
    end
    compare(tag);
  endtask

  task automatic setx(bit on, bit wr, bit fw, int a, logic [DW-1:0] d);
    xen_n = !on; xen = on; xwr = wr; xfw = fw; xa = AW'(a); xd = d;
  endtask
  task automatic sety(bit on, bit wr, bit fw, int a, logic [DW-1:0] d);
    yen_n = !on; yen = on; ywr = wr; yfw = fw; ya = AW'(a); yd = d;
  endtask
  task automatic idle();
    setx(0, 0, 0, 0, '0); sety(0, 0, 0, 0, '0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    // R10: reset state
    idle();
    setx(1, 0, 1, 3, 36'h123456789);
    sety(1, 0, 0, 3, '0);
    tick("R10"); tick("R10");
    rst_n = 1'b1;
    tick("R10");          // settling edge: request discarded
    idle();
    tick("R10"); tick("R10");

    // R3 / R11: writes on both ports, outputs hold
    for (int i = 0; i < 4; i++) begin
      setx(1, 1, 0, i, 36'hA_0000_0000 | DW'(i));
      sety(1, 1, 0, 32 + i, 36'h5_0000_0100 | DW'(i));
      tick("R3");
    end
    setx(1, 1, 0, 63, 36'hF_FFFF_FFFE);
    sety(1, 1, 0, 62, 36'h8_0000_0001);
    tick("R3");
    idle(); tick("R11"); tick("R11");

    // R1: reads, including top address, back to back
    for (int i = 0; i < 4; i++) begin
      setx(1, 0, 0, 32 + i, '0); sety(1, 0, 0, i, '0); tick("R1");
    end
    setx(1, 0, 0, 63, '0); sety(1, 0, 0, 62, '0); tick("R1");
    idle(); tick("R1"); tick("R11");

    // R2: deselect by each enable; write attempt while deselected
    setx(1, 1, 0, 1, 36'h0_DEAD_BEEF); xen_n = 1; tick("R2");
    sety(1, 1, 0, 33, 36'h0_BADC_0FFE); yen = 0; tick("R2");
    setx(1, 0, 1, 5, 36'h1_1111_1111); xen = 0;  // deselected source
    sety(1, 0, 0, 1, '0); tick("R2");
    setx(1, 0, 0, 33, '0); sety(1, 0, 0, 1, '0); tick("R2");
    idle(); tick("R2");

    // R4: X forwards to Y while Y reads, then while Y writes
    setx(1, 0, 1, 2, 36'h7_7777_0001); sety(1, 0, 0, 34, '0); tick("R4");
    setx(1, 1, 1, 4, 36'h7_7777_0002); sety(1, 1, 0, 40, 36'h3_3333_3333); tick("R4");
    // R5: Y forwards to X; then both forward at once
    setx(1, 0, 0, 34, '0); sety(1, 0, 1, 2, 36'h6_6666_0003); tick("R5");
    setx(1, 0, 1, 0, 36'h1_2345_6789); sety(1, 0, 1, 0, 36'hE_DCBA_9876); tick("R5");
    setx(1, 0, 0, 4, '0); sety(1, 0, 0, 40, '0); tick("R4");
    idle(); tick("R5");

    // R6: same address, both read
    setx(1, 0, 0, 3, '0); sety(1, 0, 0, 3, '0); tick("R6");
    idle(); tick("R6");
    // R7: X writes, Y reads same address; then reverse
    setx(1, 1, 0, 3, 36'hC_0000_0C03); sety(1, 0, 0, 3, '0); tick("R7");
    setx(1, 0, 0, 3, '0); sety(1, 1, 0, 3, 36'hC_0000_0D03); tick("R7");
    setx(1, 0, 0, 3, '0); sety(1, 0, 0, 3, '0); tick("R7");
    idle(); tick("R7");
    // R8: both write the same address
    setx(1, 1, 0, 10, 36'h1_0000_000A); sety(1, 1, 0, 10, 36'h2_0000_000A); tick("R8");
    setx(1, 0, 0, 10, '0); sety(1, 0, 0, 10, '0); tick("R8");
    idle(); tick("R8");

    // R9: output enable acts between edges
    setx(1, 0, 0, 10, '0); sety(1, 0, 0, 10, '0); tick("R9"); idle(); tick("R9");
    setx(1, 0, 0, 10, '0); sety(1, 0, 0, 3, '0); tick("R9");
    idle(); tick("R9");
    #1 xoe = 1; yoe = 1;
    #1 compare("R9");
    #1 xoe = 0;
    #1 compare("R9");
    yoe = 0;
    tick("R9");

    // R1: random mixed traffic over few addresses for frequent collisions
    for (int n = 0; n < 400; n++) begin
      setx($urandom_range(0, 4) != 0, $urandom_range(0, 1) == 1, $urandom_range(0, 3) == 0,
           int'($urandom_range(0, 7)), {4'($urandom), 32'($urandom)});
      sety($urandom_range(0, 4) != 0, $urandom_range(0, 1) == 1, $urandom_range(0, 3) == 0,
           int'($urandom_range(0, 7)), {4'($urandom), 32'($urandom)});
      xoe = ($urandom_range(0, 5) == 0);
      yoe = ($urandom_range(0, 5) == 0);
      tick("R1");
    end
    idle(); xoe = 0; yoe = 0;
    tick("R11"); tick("R11");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule